// File: doc/BRIEF.md
# Break Return Address Selector

When a user break is taken, this block works out which program-counter value goes on the stack. It also reports whether the instruction that met the break condition runs before the break. The answer depends on the kind of break condition, and on whether the matching instruction is a delayed branch or sits in a delay slot. The block is told which kind of condition matched and given five inputs:

- the address of the matching instruction,
- the address of the instruction after it,
- the branch target,
- the address of the delayed branch that owns a delay slot,
- two flags that classify the matching instruction.

The surrounding break logic pulses a take strobe in the cycle the break is accepted. One clock later the selected return address and the executed flag appear on registered outputs, together with a one-cycle valid strobe. The outputs keep their values until the next accepted break. Pipeline control and the stack write itself belong to the caller.

Condition type encoding on `cond_i`:

| Code | Meaning |
|------|---------|
| 2'b00 | fetch break, taken before the instruction runs |
| 2'b01 | fetch break, taken after the instruction runs |
| 2'b10 | data-access break on address only |
| 2'b11 | reserved |

Top module: `brk_ret_sel`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `ret_valid_o` is 0, `ret_addr_o` is 0 and `executed_o` is 0.
- R2: Code 2'b00 with `is_dslot_i` low: the stacked value is `match_addr_i` and `executed_o` is 0.
- R3: Code 2'b00 with `is_dslot_i` high: the stacked value is `owner_addr_i`, the delayed branch that owns the slot, and `executed_o` is 0.
- R4: Code 2'b01 with both `is_dbranch_i` and `is_dslot_i` low: the stacked value is `next_addr_i` and `executed_o` is 1.
- R5: Code 2'b01 with `is_dbranch_i` or `is_dslot_i` high: the stacked value is `target_addr_i` and `executed_o` is 1.
- R6: Code 2'b10 with `is_dslot_i` low, whatever `is_dbranch_i` is: the stacked value is `next_addr_i` and `executed_o` is 1.
- R7: Code 2'b10 with `is_dslot_i` high: the stacked value is `target_addr_i` and `executed_o` is 1.
- R8: `ret_valid_o` is high for exactly the one cycle after an edge at which `take_i` was high with a non-reserved code. It is low in every other cycle.
- R9: A take with the reserved code 2'b11 raises no valid strobe and leaves `ret_addr_o` and `executed_o` unchanged.
- R10: Bit 0 of `ret_addr_o` is always 0. The selected address is taken with bit 0 cleared.
- R11: With `take_i` low, `ret_addr_o` and `executed_o` hold their values, whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| take_i | input | 1 | Break-accepted strobe |
| cond_i | input | 2 | Condition type code, as listed in the encoding table |
| is_dbranch_i | input | 1 | Matching instruction is a delayed branch |
| is_dslot_i | input | 1 | Matching instruction is in a delay slot |
| match_addr_i | input | 32 | Address of the matching instruction |
| next_addr_i | input | 32 | Address of the following instruction |
| target_addr_i | input | 32 | Branch target address |
| owner_addr_i | input | 32 | Address of the delayed branch owning the slot |
| ret_valid_o | output | 1 | One-cycle return address valid strobe |
| ret_addr_o | output | 32 | Return address to stack |
| executed_o | output | 1 | Matching instruction runs before the break |

## Verification
Every result is due exactly one clock after the edge that samples `take_i`. At that point the address, the executed flag and the valid strobe all update together, and the strobe falls one clock later. The bench drives inputs on the falling edge and reads the outputs at the next falling edge, halfway through the cycle that follows the capturing edge. After each take it sets `take_i` low, changes every data input, and reads again one falling edge later to confirm that the strobe has dropped and the held values have not moved.

// File: rtl/brk_ret_pkg.sv
package brk_ret_pkg;

  typedef enum logic [1:0] {
    COND_FETCH_PRE  = 2'b00,
    COND_FETCH_POST = 2'b01,
    COND_DATA_ADDR  = 2'b10,
    COND_RSVD       = 2'b11
  } brk_cond_e;

  typedef enum logic [1:0] {
    SRC_MATCH  = 2'b00,
    SRC_OWNER  = 2'b01,
    SRC_NEXT   = 2'b10,
    SRC_TARGET = 2'b11
  } ret_src_e;

endpackage

// File: rtl/brk_rule_decode.sv
module brk_rule_decode
  import brk_ret_pkg::*;
(
  input  brk_cond_e cond,
  input  logic      is_dbranch,
  input  logic      is_dslot,
  output ret_src_e  src,
  output logic      executed,
  output logic      legal
);

  always_comb begin
    src      = SRC_MATCH;
    executed = 1'b0;
    legal    = 1'b1;
    unique case (cond)
      COND_FETCH_PRE: begin
        // Instruction is held back; a slot instruction resumes at its branch.
        src      = is_dslot ? SRC_OWNER : SRC_MATCH;
        executed = 1'b0;
      end
      COND_FETCH_POST: begin
        // Branch and slot both complete, so resume at the target.
        src      = (is_dbranch | is_dslot) ? SRC_TARGET : SRC_NEXT;
        executed = 1'b1;
      end
      COND_DATA_ADDR: begin
        src      = is_dslot ? SRC_TARGET : SRC_NEXT;
        executed = 1'b1;
      end
      default: begin
        legal = 1'b0;
      end
    endcase
  end

endmodule

// File: rtl/brk_addr_mux.sv
module brk_addr_mux
  import brk_ret_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int ALIGN_W = 1
) (
  input  ret_src_e          src,
  input  logic [ADDR_W-1:0] match_addr,
  input  logic [ADDR_W-1:0] owner_addr,
  input  logic [ADDR_W-1:0] next_addr,
  input  logic [ADDR_W-1:0] target_addr,
  output logic [ADDR_W-1:0] ret_addr
);

  logic [ADDR_W-1:0] picked;

  always_comb begin
    unique case (src)
      SRC_MATCH:  picked = match_addr;
      SRC_OWNER:  picked = owner_addr;
      SRC_NEXT:   picked = next_addr;
      default:    picked = target_addr;
    endcase
  end

  generate
    if (ALIGN_W > 0) begin : g_align
      assign ret_addr = {picked[ADDR_W-1:ALIGN_W], {ALIGN_W{1'b0}}};
    end else begin : g_raw
      assign ret_addr = picked;
    end
  endgenerate

endmodule

// File: rtl/brk_out_reg.sv
module brk_out_reg #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [ADDR_W-1:0] d_addr,
  input  logic              d_exec,
  output logic              q_valid,
  output logic [ADDR_W-1:0] q_addr,
  output logic              q_exec
);

  always_ff @(posedge clk) begin
    if (rst) begin
      q_valid <= 1'b0;
      q_addr  <= '0;
      q_exec  <= 1'b0;
    end else begin
      q_valid <= load;
      if (load) begin
        q_addr <= d_addr;
        q_exec <= d_exec;
      end
    end
  end

endmodule

// File: rtl/brk_ret_sel.sv
module brk_ret_sel
  import brk_ret_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int ALIGN_W = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              take_i,
  input  logic [1:0]        cond_i,
  input  logic              is_dbranch_i,
  input  logic              is_dslot_i,
  input  logic [ADDR_W-1:0] match_addr_i,
  input  logic [ADDR_W-1:0] next_addr_i,
  input  logic [ADDR_W-1:0] target_addr_i,
  input  logic [ADDR_W-1:0] owner_addr_i,
  output logic              ret_valid_o,
  output logic [ADDR_W-1:0] ret_addr_o,
  output logic              executed_o
);

  ret_src_e          src;
  logic              exec_d;
  logic              legal;
  logic [ADDR_W-1:0] addr_d;

  brk_rule_decode u_dec (
    .cond       (brk_cond_e'(cond_i)),
    .is_dbranch (is_dbranch_i),
    .is_dslot   (is_dslot_i),
    .src        (src),
    .executed   (exec_d),
    .legal      (legal)
  );

  brk_addr_mux #(.ADDR_W(ADDR_W), .ALIGN_W(ALIGN_W)) u_mux (
    .src         (src),
    .match_addr  (match_addr_i),
    .owner_addr  (owner_addr_i),
    .next_addr   (next_addr_i),
    .target_addr (target_addr_i),
    .ret_addr    (addr_d)
  );

  brk_out_reg #(.ADDR_W(ADDR_W)) u_reg (
    .clk     (clk),
    .rst     (rst),
    .load    (take_i & legal),
    .d_addr  (addr_d),
    .d_exec  (exec_d),
    .q_valid (ret_valid_o),
    .q_addr  (ret_addr_o),
    .q_exec  (executed_o)
  );

endmodule

// File: rtl/brk_ret_sel_chk.sv
module brk_ret_sel_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              take_i,
  input logic [1:0]        cond_i,
  input logic              is_dbranch_i,
  input logic              is_dslot_i,
  input logic [ADDR_W-1:0] match_addr_i,
  input logic [ADDR_W-1:0] next_addr_i,
  input logic [ADDR_W-1:0] target_addr_i,
  input logic [ADDR_W-1:0] owner_addr_i,
  input logic              ret_valid_o,
  input logic [ADDR_W-1:0] ret_addr_o,
  input logic              executed_o
);

  assert_pre_match_R2: assert property (@(posedge clk) disable iff (rst)
    (take_i && cond_i == 2'b00 && !is_dslot_i) |=>
      (ret_addr_o == {$past(match_addr_i[ADDR_W-1:1]), 1'b0}) && !executed_o);

  assert_pre_owner_R3: assert property (@(posedge clk) disable iff (rst)
    (take_i && cond_i == 2'b00 && is_dslot_i) |=>
      (ret_addr_o == {$past(owner_addr_i[ADDR_W-1:1]), 1'b0}) && !executed_o);

  assert_post_target_R5: assert property (@(posedge clk) disable iff (rst)
    (take_i && cond_i == 2'b01 && (is_dbranch_i || is_dslot_i)) |=>
      (ret_addr_o == {$past(target_addr_i[ADDR_W-1:1]), 1'b0}) && executed_o);

  assert_data_next_R6: assert property (@(posedge clk) disable iff (rst)
    (take_i && cond_i == 2'b10 && !is_dslot_i) |=>
      (ret_addr_o == {$past(next_addr_i[ADDR_W-1:1]), 1'b0}) && executed_o);

  assert_valid_cause_R8: assert property (@(posedge clk) disable iff (rst)
    ret_valid_o |-> ($past(take_i) && $past(cond_i) != 2'b11));

  assert_rsvd_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    (take_i && cond_i == 2'b11) |=> (!ret_valid_o && $stable(ret_addr_o)));

  assert_align_R10: assert property (@(posedge clk) disable iff (rst)
    !ret_addr_o[0]);

  assert_hold_R11: assert property (@(posedge clk) disable iff (rst)
    !take_i |=> ($stable(ret_addr_o) && $stable(executed_o)));

endmodule

bind brk_ret_sel brk_ret_sel_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .take_i        (take_i),
  .cond_i        (cond_i),
  .is_dbranch_i  (is_dbranch_i),
  .is_dslot_i    (is_dslot_i),
  .match_addr_i  (match_addr_i),
  .next_addr_i   (next_addr_i),
  .target_addr_i (target_addr_i),
  .owner_addr_i  (owner_addr_i),
  .ret_valid_o   (ret_valid_o),
  .ret_addr_o    (ret_addr_o),
  .executed_o    (executed_o)
);

// File: tb/brk_ret_sel_bench.sv
module brk_ret_sel_bench;

  logic        clk = 1'b0;
  logic        rst;
  logic        take_i;
  logic [1:0]  cond_i;
  logic        is_dbranch_i;
  logic        is_dslot_i;
  logic [31:0] match_addr_i, next_addr_i, target_addr_i, owner_addr_i;
  logic        ret_valid_o;
  logic [31:0] ret_addr_o;
  logic        executed_o;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  brk_ret_sel u_brk_ret_sel (
    .clk           (clk),
    .rst           (rst),
    .take_i        (take_i),
    .cond_i        (cond_i),
    .is_dbranch_i  (is_dbranch_i),
    .is_dslot_i    (is_dslot_i),
    .match_addr_i  (match_addr_i),
    .next_addr_i   (next_addr_i),
    .target_addr_i (target_addr_i),
    .owner_addr_i  (owner_addr_i),
    .ret_valid_o   (ret_valid_o),
    .ret_addr_o    (ret_addr_o),
    .executed_o    (executed_o)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] base_of(int k);
    return 32'h4000_0001 + 32'(k) * 32'h0101_0ACB;
  endfunction

  task automatic drive_addrs(int k);
    match_addr_i  = base_of(k);
    next_addr_i   = base_of(k) + 32'd2;
    target_addr_i = base_of(k) ^ 32'h00F0_1235;
    owner_addr_i  = base_of(k) - 32'd2;
  endtask

  function automatic string tag_of(int c, bit dbr, bit ds);
    case (c)
      0:       return ds ? "R3" : "R2";
      1:       return (dbr || ds) ? "R5" : "R4";
      2:       return ds ? "R7" : "R6";
      default: return "R9";
    endcase
  endfunction

  function automatic logic [31:0] exp_addr(int c, bit dbr, bit ds);
    logic [31:0] a;
    case (c)
      0:       a = ds ? owner_addr_i : match_addr_i;
      1:       a = (dbr || ds) ? target_addr_i : next_addr_i;
      default: a = ds ? target_addr_i : next_addr_i;
    endcase
    return a & ~32'd1;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] held_addr;
    logic        held_exec;
    rst = 1'b1; take_i = 1'b0; cond_i = 2'b00;
    is_dbranch_i = 1'b0; is_dslot_i = 1'b0;
    drive_addrs(0);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 valid", 32'(ret_valid_o), 32'd0);
    check("R1 addr",  ret_addr_o,       32'd0);
    check("R1 exec",  32'(executed_o),  32'd0);
    held_addr = 32'd0;
    held_exec = 1'b0;

    for (int k = 0; k < 6; k++) begin
      for (int c = 0; c < 4; c++) begin
        for (int f = 0; f < 4; f++) begin
          bit dbr = f[0];
          bit ds  = f[1];
          int idx = k * 16 + c * 4 + f;
          drive_addrs(idx);
          cond_i       = c[1:0];
          is_dbranch_i = dbr;
          is_dslot_i   = ds;
          take_i       = 1'b1;
          if (c != 3) begin
            held_addr = exp_addr(c, dbr, ds);
            held_exec = (c != 0);
          end
          @(negedge clk);
          check((c == 3) ? "R9 valid" : "R8 valid", 32'(ret_valid_o), (c == 3) ? 32'd0 : 32'd1);
          check(tag_of(c, dbr, ds), ret_addr_o, held_addr);
          check({tag_of(c, dbr, ds), " exec"}, 32'(executed_o), 32'(held_exec));
          check("R10 bit0", 32'(ret_addr_o[0]), 32'd0);
          // Idle cycle with new data: outputs must not follow it.
          take_i       = 1'b0;
          cond_i       = 2'(idx + 1);
          is_dbranch_i = ~dbr;
          is_dslot_i   = ~ds;
          drive_addrs(idx + 500);
          @(negedge clk);
          check("R8 strobe drop", 32'(ret_valid_o), 32'd0);
          check("R11 addr hold",  ret_addr_o,       held_addr);
          check("R11 exec hold",  32'(executed_o),  32'(held_exec));
        end
      end
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule